// File: doc/BRIEF.md
# Grouped Multiplicity Coincidence Trigger

This block sits on the collecting side of a multi-frontend digitizer and reduces the per-frontend trigger information to one local trigger. Every frontend reports a hit multiplicity of 0 to 8 and a single "any hit" bit. A 64-bit configuration word comes in as a low and a high 32-bit half. It places each frontend into one of several logical groups and gives every group its own multiplicity threshold. It also chooses which groups take part in the coincidence.

In multiplicity mode, the multiplicities of the frontends in each group are added together, and each sum is compared with that group's threshold. A trigger is raised only when every enabled group passes in the same cycle. Two mode bits in the configuration choose among three trigger sources: an external link trigger, this grouped multiplicity trigger, or a plain OR of the frontends' hit bits. The result is registered, and a one-cycle pulse marks each rising edge of the trigger.

Top module: `mult_coinc_trigger`

## Requirements
- R1: While reset is active, and in the first sampled cycle after it, both outputs are 0. Outside reset, `trig_o` shows the source selected from the inputs present at the previous rising clock edge, so it has exactly one cycle of latency.
- R2: When configuration bit 2 is 1, `trig_o` follows `ext_trig_i`. The other mode bit, the hit bits and the multiplicities are then ignored.
- R3: When configuration bits 2 and 1 are both 0, `trig_o` is the OR of the six `fe_or_i` bits. `ext_trig_i` and the multiplicities are ignored.
- R4: Group g's 6-bit threshold sits at configuration bits [4+6g +: 6], with group 0 lowest. Bits 39..4 hold all six.
- R5: Frontend f's 3-bit group ID sits at configuration bits [40+3f +: 3], with frontend 0 lowest. An ID of 6 or 7 names no group, so that frontend adds to no sum.
- R6: A group passes when its summed multiplicity is greater than or equal to its threshold. Equality passes.
- R7: In multiplicity mode (bit 2 = 0, bit 1 = 1), a trigger needs every group whose enable bit at configuration bit 58+g is 1 to pass in the same cycle. Groups that are not enabled do not affect the result.
- R8: In multiplicity mode, when no group is enabled, no trigger is produced. An enabled group with no frontends assigned has a sum of 0, so it passes only with threshold 0.
- R9: A reported multiplicity above 8 counts as 8.
- R10: `trig_pulse_o` is 1 for exactly the cycle in which `trig_o` goes from 0 to 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fe_mult_i | input | 24 | Per-frontend multiplicity, 4 bits each, frontend 0 in bits 3..0 |
| fe_or_i | input | 6 | Per-frontend any-hit bit |
| ext_trig_i | input | 1 | Trigger arriving on the external link |
| cfg_lo_i | input | 32 | Configuration bits 31..0 |
| cfg_hi_i | input | 32 | Configuration bits 63..32 |
| trig_o | output | 1 | Registered local trigger |
| trig_pulse_o | output | 1 | One-cycle pulse on each rising edge of the trigger |

## Verification
Every result of this block is due one rising edge after its inputs change. One register stands between the inputs and `trig_o`, and `trig_pulse_o` is updated at the same edge. The bench therefore changes inputs on a falling edge and samples both outputs on the next falling edge, half a period after the capturing edge. The expected pulse is derived from the previous expected trigger level, so every step checks the edge detector as well.

// File: rtl/mct_pkg.sv
package mct_pkg;
   localparam int CFG_W         = 64;
   localparam int HALF_W        = 32;
   localparam int MODE_MULT_BIT = 1;
   localparam int MODE_EXT_BIT  = 2;
   localparam int THR_LSB       = 4;
   localparam int FE_MULT_MAX   = 8;

   typedef enum logic [1:0] {
      SRC_GRAND_OR = 2'd0,
      SRC_MULT     = 2'd1,
      SRC_LINK     = 2'd2
   } trig_src_e;
endpackage

// File: rtl/mct_cfg_unpack.sv
module mct_cfg_unpack
   import mct_pkg::*;
#(
   parameter int NUM_FE  = 6,
   parameter int NUM_GRP = 6,
   parameter int THR_W   = 6,
   parameter int GID_W   = 3
) (
   input  logic [CFG_W-1:0]         cfg_i,
   output logic [NUM_GRP*THR_W-1:0] thr_o,
   output logic [NUM_FE*GID_W-1:0]  gid_o,
   output logic [NUM_GRP-1:0]       en_o,
   output trig_src_e                src_o
);
   localparam int GID_LSB = THR_LSB + NUM_GRP*THR_W;
   localparam int EN_LSB  = GID_LSB + NUM_FE*GID_W;
   localparam int EN_END  = EN_LSB + NUM_GRP;

   assign thr_o = cfg_i[THR_LSB +: NUM_GRP*THR_W];
   assign gid_o = cfg_i[GID_LSB +: NUM_FE*GID_W];
   assign en_o  = cfg_i[EN_LSB  +: NUM_GRP];

   always_comb begin
      if (cfg_i[MODE_EXT_BIT])       src_o = SRC_LINK;
      else if (cfg_i[MODE_MULT_BIT]) src_o = SRC_MULT;
      else                           src_o = SRC_GRAND_OR;
   end

   logic unused_spare;
   generate
      if (EN_END < CFG_W) begin : g_spare
         assign unused_spare = ^{cfg_i[0], cfg_i[3], cfg_i[CFG_W-1:EN_END]};
      end else begin : g_full
         assign unused_spare = ^{cfg_i[0], cfg_i[3]};
      end
   endgenerate
endmodule

// File: rtl/mct_group_sum.sv
module mct_group_sum
   import mct_pkg::*;
#(
   parameter int NUM_FE  = 6,
   parameter int NUM_GRP = 6,
   parameter int MULT_W  = 4,
   parameter int GID_W   = 3,
   parameter int SUM_W   = 6
) (
   input  logic [NUM_FE*MULT_W-1:0] mult_i,
   input  logic [NUM_FE*GID_W-1:0]  gid_i,
   output logic [NUM_GRP*SUM_W-1:0] sum_o
);
   localparam int CL_W = $clog2(FE_MULT_MAX + 1);

   logic [CL_W-1:0] clamped [NUM_FE];

   generate
      for (genvar f = 0; f < NUM_FE; f++) begin : g_fe
         if ((2**MULT_W) - 1 > FE_MULT_MAX) begin : g_sat
            assign clamped[f] = (mult_i[f*MULT_W +: MULT_W] > MULT_W'(FE_MULT_MAX))
                              ? CL_W'(FE_MULT_MAX)
                              : CL_W'(mult_i[f*MULT_W +: MULT_W]);
         end else begin : g_pass
            assign clamped[f] = CL_W'(mult_i[f*MULT_W +: MULT_W]);
         end
      end

      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         logic [SUM_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int f = 0; f < NUM_FE; f++) begin
               if (gid_i[f*GID_W +: GID_W] == GID_W'(g))
                  acc = acc + SUM_W'(clamped[f]);
            end
         end
         assign sum_o[g*SUM_W +: SUM_W] = acc;
      end
   endgenerate
endmodule

// File: rtl/mct_group_judge.sv
module mct_group_judge #(
   parameter int NUM_GRP = 6,
   parameter int SUM_W   = 6,
   parameter int THR_W   = 6
) (
   input  logic [NUM_GRP*SUM_W-1:0] sum_i,
   input  logic [NUM_GRP*THR_W-1:0] thr_i,
   input  logic [NUM_GRP-1:0]       en_i,
   output logic                     hit_o
);
   localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

   logic [NUM_GRP-1:0] pass;

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_cmp
         assign pass[g] = CMP_W'(sum_i[g*SUM_W +: SUM_W]) >= CMP_W'(thr_i[g*THR_W +: THR_W]);
      end
   endgenerate

   assign hit_o = (|en_i) & (&(pass | ~en_i));
endmodule

// File: rtl/mult_coinc_trigger.sv
module mult_coinc_trigger
   import mct_pkg::*;
#(
   parameter int NUM_FE  = 6,
   parameter int NUM_GRP = 6,
   parameter int MULT_W  = 4,
   parameter int THR_W   = 6,
   parameter int GID_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_FE*MULT_W-1:0] fe_mult_i,
   input  logic [NUM_FE-1:0]        fe_or_i,
   input  logic                     ext_trig_i,
   input  logic [HALF_W-1:0]        cfg_lo_i,
   input  logic [HALF_W-1:0]        cfg_hi_i,
   output logic                     trig_o,
   output logic                     trig_pulse_o
);
   localparam int SUM_W  = $clog2(NUM_FE*FE_MULT_MAX + 1);
   localparam int EN_END = THR_LSB + NUM_GRP*THR_W + NUM_FE*GID_W + NUM_GRP;

   generate
      if (EN_END > CFG_W) begin : g_bad_layout
         $error("configuration fields do not fit in the configuration word");
      end
      if (NUM_GRP > 2**GID_W) begin : g_bad_gid
         $error("group ID width cannot name every group");
      end
      if (MULT_W < $clog2(FE_MULT_MAX + 1)) begin : g_bad_mult
         $error("multiplicity width cannot carry the full range");
      end
   endgenerate

   logic [CFG_W-1:0]         cfg;
   logic [NUM_GRP*THR_W-1:0] grp_thr;
   logic [NUM_FE*GID_W-1:0]  fe_gid;
   logic [NUM_GRP-1:0]       grp_en;
   logic [NUM_GRP*SUM_W-1:0] grp_sum;
   trig_src_e                src_sel;
   logic                     mult_hit;
   logic                     trig_nxt;

   assign cfg = {cfg_hi_i, cfg_lo_i};

   mct_cfg_unpack #(
      .NUM_FE (NUM_FE),
      .NUM_GRP(NUM_GRP),
      .THR_W  (THR_W),
      .GID_W  (GID_W)
   ) u_unpack (
      .cfg_i(cfg),
      .thr_o(grp_thr),
      .gid_o(fe_gid),
      .en_o (grp_en),
      .src_o(src_sel)
   );

   mct_group_sum #(
      .NUM_FE (NUM_FE),
      .NUM_GRP(NUM_GRP),
      .MULT_W (MULT_W),
      .GID_W  (GID_W),
      .SUM_W  (SUM_W)
   ) u_sum (
      .mult_i(fe_mult_i),
      .gid_i (fe_gid),
      .sum_o (grp_sum)
   );

   mct_group_judge #(
      .NUM_GRP(NUM_GRP),
      .SUM_W  (SUM_W),
      .THR_W  (THR_W)
   ) u_judge (
      .sum_i(grp_sum),
      .thr_i(grp_thr),
      .en_i (grp_en),
      .hit_o(mult_hit)
   );

   always_comb begin
      unique case (src_sel)
         SRC_LINK: trig_nxt = ext_trig_i;
         SRC_MULT: trig_nxt = mult_hit;
         default:  trig_nxt = |fe_or_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_o       <= 1'b0;
         trig_pulse_o <= 1'b0;
      end else begin
         trig_o       <= trig_nxt;
         trig_pulse_o <= trig_nxt & ~trig_o;
      end
   end
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
   parameter int NUM_FE  = 6,
   parameter int NUM_GRP = 6,
   parameter int SUM_W   = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     mode_ext,
   input logic                     mode_mult,
   input logic [NUM_GRP-1:0]       grp_en,
   input logic [NUM_GRP*SUM_W-1:0] grp_sum,
   input logic [NUM_FE-1:0]        fe_or_i,
   input logic                     ext_trig_i,
   input logic                     trig_o,
   input logic                     trig_pulse_o
);
   localparam int TOT_W   = SUM_W + $clog2(NUM_GRP + 1);
   localparam int SUM_MAX = NUM_FE * mct_pkg::FE_MULT_MAX;

   logic [TOT_W-1:0] total;
   always_comb begin
      total = '0;
      for (int g = 0; g < NUM_GRP; g++)
         total = total + TOT_W'(grp_sum[g*SUM_W +: SUM_W]);
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!trig_o && !trig_pulse_o)); // R1

   AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ext |=> (trig_o == $past(ext_trig_i))); // R2

   AST_OR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ext && !mode_mult) |=> (trig_o == $past(|fe_or_i))); // R3

   AST_NO_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_ext && mode_mult && grp_en == '0) |=> !trig_o); // R8

   AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      total <= TOT_W'(SUM_MAX)); // R9

   AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse_o |-> (trig_o && !$past(trig_o))); // R10

   AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && !$past(trig_o)) |-> trig_pulse_o); // R10
endmodule

bind mult_coinc_trigger mct_checker #(
   .NUM_FE (NUM_FE),
   .NUM_GRP(NUM_GRP),
   .SUM_W  (SUM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_ext    (cfg_lo_i[mct_pkg::MODE_EXT_BIT]),
   .mode_mult   (cfg_lo_i[mct_pkg::MODE_MULT_BIT]),
   .grp_en      (grp_en),
   .grp_sum     (grp_sum),
   .fe_or_i     (fe_or_i),
   .ext_trig_i  (ext_trig_i),
   .trig_o      (trig_o),
   .trig_pulse_o(trig_pulse_o)
);

// File: tb/tb_mult_coinc_trigger.sv
module tb_mult_coinc_trigger;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] fe_mult;
   logic [5:0]  fe_or = '0;
   logic        ext_trig = 1'b0;
   logic [63:0] cfg;
   logic        trig, trig_pulse;

   logic        m_ext = 1'b0, m_mult = 1'b0;
   logic [5:0]  en = '0;
   logic [3:0]  mult [6];
   logic [5:0]  thr  [6];
   logic [2:0]  gid  [6];

   int checks = 0, failures = 0;
   logic prev_exp = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      cfg = '0;
      cfg[1] = m_mult;
      cfg[2] = m_ext;
      for (int g = 0; g < 6; g++) cfg[4 + 6*g +: 6] = thr[g];
      for (int f = 0; f < 6; f++) cfg[40 + 3*f +: 3] = gid[f];
      cfg[63:58] = en;
      for (int f = 0; f < 6; f++) fe_mult[4*f +: 4] = mult[f];
   end

   mult_coinc_trigger dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .fe_mult_i   (fe_mult),
      .fe_or_i     (fe_or),
      .ext_trig_i  (ext_trig),
      .cfg_lo_i    (cfg[31:0]),
      .cfg_hi_i    (cfg[63:32]),
      .trig_o      (trig),
      .trig_pulse_o(trig_pulse)
   );

   task automatic clear_cfg();
      for (int i = 0; i < 6; i++) begin
         mult[i] = '0; thr[i] = '0; gid[i] = '0;
      end
      en = '0; fe_or = '0; ext_trig = 1'b0; m_ext = 1'b0; m_mult = 1'b0;
   endtask

   // inputs were changed at a falling edge; one rising edge captures them
   task automatic step(input logic exp, input string req);
      logic exp_pulse;
      exp_pulse = exp & ~prev_exp;
      @(negedge clk);
      checks++;
      if (trig !== exp) begin
         failures++;
         $display("FAIL %s trig_o actual=%b expected=%b", req, trig, exp);
      end
      checks++;
      if (trig_pulse !== exp_pulse) begin
         failures++;
         $display("FAIL R10 (%s) trig_pulse_o actual=%b expected=%b", req, trig_pulse, exp_pulse);
      end
      prev_exp = exp;
   endtask

   task automatic t_reset();
      clear_cfg();
      fe_or = '1; ext_trig = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (trig !== 1'b0 || trig_pulse !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset outputs actual=%b%b expected=00", trig, trig_pulse);
      end
      clear_cfg();
      rst_n = 1'b1;
      prev_exp = 1'b0;
      step(1'b0, "R1 first cycle after reset");
   endtask

   task automatic t_grand_or();
      clear_cfg();
      fe_or = 6'b000100;            step(1'b1, "R3 one hit bit");
      fe_or = 6'b100001;            step(1'b1, "R3 two hit bits");
      fe_or = '0; ext_trig = 1'b1;  step(1'b0, "R3 link ignored");
      mult[0] = 4'd8;               step(1'b0, "R3 multiplicity ignored");
   endtask

   task automatic t_link();
      clear_cfg();
      m_ext = 1'b1; m_mult = 1'b1; ext_trig = 1'b1;  step(1'b1, "R2 link high");
      ext_trig = 1'b0; fe_or = '1;                    step(1'b0, "R2 hit bits ignored");
      en = 6'b000001; mult[0] = 4'd8;                 step(1'b0, "R2 multiplicity ignored");
   endtask

   task automatic t_threshold();
      clear_cfg();
      m_mult = 1'b1; en = 6'b000001; thr[0] = 6'd10;
      mult[0] = 2; mult[1] = 2; mult[2] = 2; mult[3] = 2; mult[4] = 1;
      step(1'b0, "R6 sum 9 below 10");
      mult[5] = 1;      step(1'b1, "R6 sum equals threshold");
      thr[0] = 6'd11;   step(1'b0, "R4 R6 raised threshold");
      thr[0] = 6'd3;    step(1'b1, "R4 lowered threshold");
   endtask

   task automatic t_coincidence();
      clear_cfg();
      m_mult = 1'b1;
      gid[0] = 1; gid[1] = 1; gid[2] = 1; gid[3] = 3; gid[4] = 3; gid[5] = 3;
      thr[1] = 6'd5; thr[3] = 6'd4; en = 6'b001010;
      mult[0] = 2; mult[1] = 2; mult[2] = 1;
      step(1'b0, "R7 only group 1 passes");
      mult[3] = 2; mult[4] = 1; mult[5] = 1;
      step(1'b1, "R5 R7 both groups pass");
      mult[2] = 0;
      step(1'b0, "R7 group 1 drops");
      en = 6'b001000;
      step(1'b1, "R7 disabled group ignored");
      en = 6'b101000; thr[5] = 6'd1;
      step(1'b0, "R8 empty group fails threshold 1");
      thr[5] = 6'd0;
      step(1'b1, "R8 empty group passes threshold 0");
   endtask

   task automatic t_group_id();
      clear_cfg();
      m_mult = 1'b1; en = 6'b000001; thr[0] = 6'd8;
      mult[5] = 8; gid[5] = 3'd7;
      step(1'b0, "R5 id 7 counts nowhere");
      gid[5] = 3'd0;
      step(1'b1, "R5 frontend 5 in group 0");
      gid[5] = 3'd6; en = 6'b111111;
      step(1'b0, "R5 id 6 counts nowhere");
   endtask

   task automatic t_none_enabled();
      clear_cfg();
      m_mult = 1'b1;
      for (int f = 0; f < 6; f++) mult[f] = 4'd8;
      fe_or = '1;
      step(1'b0, "R8 no group enabled");
   endtask

   task automatic t_clamp();
      clear_cfg();
      m_mult = 1'b1; en = 6'b000001; thr[0] = 6'd9;
      mult[0] = 4'd15;  step(1'b0, "R9 15 counts as 8");
      mult[1] = 4'd1;   step(1'b1, "R9 8 plus 1 meets 9");
      for (int f = 0; f < 6; f++) mult[f] = 4'd15;
      thr[0] = 6'd48;   step(1'b1, "R9 six saturated sum 48");
      thr[0] = 6'd49;   step(1'b0, "R9 sum stays 48");
   endtask

   task automatic t_pulse();
      clear_cfg();
      fe_or = 6'b000001;  step(1'b1, "R10 rise");
                          step(1'b1, "R10 held level");
      fe_or = '0;         step(1'b0, "R10 fall");
      fe_or = 6'b010000;  step(1'b1, "R10 second rise");
   endtask

   initial begin
      clear_cfg();
      t_reset();
      t_grand_or();
      t_link();
      t_threshold();
      t_coincidence();
      t_group_id();
      t_none_enabled();
      t_clamp();
      t_pulse();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule